// File: doc/BRIEF.md
# Register Rename Map and Free List

This block performs explicit register renaming for a front end that decodes up to two instructions per cycle. Thirty-two architectural registers are mapped onto sixty-four physical registers. In each group the block translates every source through the map table, gives every instruction that writes a register a fresh physical destination from a circular free list, reports the physical register that the destination was mapped to before, and writes the new mapping back into the table. The two slots of one group are renamed together. When the second slot reads or rewrites a register that the first slot writes, it sees the first slot's new physical register in the same cycle.

The old mapping that a writer reports goes down the pipeline with the instruction. When the instruction commits, the pipeline returns that physical register on one of the two free ports, and it joins the tail of the free list. Architectural register 0 is fixed to physical register 0. It is never renamed and is never released.

The decoded group enters on a valid/ready handshake. The renamed group leaves on a valid/ready handshake in the same cycle, with no register stage in between. A group is taken, and the block state changes, only when `in_valid` and `in_ready` are both high. `in_ready` does not depend on `in_valid`. `out_valid` does not depend on `out_ready`. While the handshake is stalled the producer must hold the group stable. The commit free ports are plain strobes with no back-pressure.

Top module: `rename_unit`

## Requirements
- R1: After reset, architectural register i maps to physical register i for i = 0..31, and the free list holds the 32 registers 32..63. They are handed out in ascending order.
- R2: Each slot's two source fields (slot j at bits [5j+4:5j]) come out translated through the current map on `out_psrca`/`out_psrcb` (slot j at bits [6j+5:6j]). Register 0 always translates to physical register 0. Sources are translated even for a slot whose valid bit is low.
- R3: A slot is a writer when its valid bit, its write bit and a nonzero destination are all present. Writers take physical registers from the free list head in slot order: slot 0 takes the head, and slot 1 takes the next entry, or the head when slot 0 is not a writer. Two writers in one group never get the same register.
- R4: Each writer reports on `out_pold` the mapping that its destination had before this group. When the group is accepted, the map entry of the destination becomes the new register, and later groups see that mapping.
- R5: A slot 1 source that names slot 0's destination, where slot 0 is a writer, translates to slot 0's new register in the same cycle.
- R6: When both slots write the same register, slot 1's old mapping is slot 0's new register, and the map ends holding slot 1's new register.
- R7: A slot that is not a writer, including a write to register 0, reports 0 on `out_pdst` and `out_pold`. It takes nothing from the free list and leaves the map unchanged.
- R8: Each `cm_free[j]` bit appends `cm_preg` slot j to the free list tail at the clock edge, with slot 0 ahead of slot 1. Returned registers are handed out only after every register that was already queued.
- R9: `in_ready` is low when the free list, counted at the start of the cycle, holds fewer registers than the group has writers. A register returned in the same cycle does not count. A group with no writers is accepted even when the list is empty.
- R10: `out_valid` equals `in_valid` while there is enough room. `in_ready` is low whenever `out_ready` is low. Without acceptance nothing is allocated and the map does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded group present |
| in_ready | output | 1 | Group accepted this cycle when in_valid is also high |
| in_slot_vld | input | 2 | Per-slot instruction present |
| in_wr | input | 2 | Per-slot writes a destination register |
| in_dst | input | 10 | Per-slot architectural destination, 5 bits each |
| in_srca | input | 10 | Per-slot first architectural source |
| in_srcb | input | 10 | Per-slot second architectural source |
| out_valid | output | 1 | Renamed group present |
| out_ready | input | 1 | Consumer takes the renamed group |
| out_pdst | output | 12 | Per-slot new physical destination, 6 bits each |
| out_pold | output | 12 | Per-slot previous mapping of the destination |
| out_psrca | output | 12 | Per-slot translated first source |
| out_psrcb | output | 12 | Per-slot translated second source |
| cm_free | input | 2 | Per-slot return strobe for a committed old mapping |
| cm_preg | input | 12 | Per-slot physical register being returned |

## Verification
The bench targets same-group dependences. A design without forwarding would hand slot 1 the stale map value. Back-to-back writes to one register would then leave the older mapping in the table, or report the wrong old register. The bench drains the free list to exactly empty and checks that returned registers come out after the original pool, which catches tail pointers that wrap wrongly. It also checks that a register returned in the same cycle as an allocation attempt does not lift the stall, and that a writer-free group still passes on an empty list. It checks that a write to register 0 neither allocates nor disturbs the map, and that a stalled group consumes nothing.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int RN_AREGS = 32;
  localparam int RN_PREGS = 64;
  localparam int RN_GROUP = 2;
endpackage

// File: rtl/rn_free_list.sv
// Circular queue of free physical registers. DEPTH must be a power of two.
module rn_free_list #(
  parameter int DEPTH = 64,
  parameter int PW    = 6,
  parameter int GROUP = 2,
  parameter int NFREE = 32,
  parameter int FIRST = 32
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [$clog2(GROUP+1)-1:0]          pop_cnt,
  input  logic [GROUP-1:0]                    push_vld,
  input  logic [GROUP*PW-1:0]                 push_preg,
  output logic [GROUP*PW-1:0]                 peek,
  output logic [$clog2(DEPTH+1)-1:0]          count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam int GW = $clog2(GROUP+1);

  logic [PW-1:0] slots [DEPTH];
  logic [AW-1:0] head_q, tail_q;
  logic [AW-1:0] wpos [GROUP];
  logic [GW-1:0] npush;

  for (genvar k = 0; k < GROUP; k++) begin : g_peek
    assign peek[k*PW +: PW] = slots[head_q + AW'(k)];
  end

  // compact the returning registers onto consecutive tail positions
  always_comb begin
    npush = '0;
    for (int k = 0; k < GROUP; k++) begin
      wpos[k] = tail_q + AW'(npush);
      if (push_vld[k]) npush = npush + GW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)
        slots[i] <= (i < NFREE) ? PW'(FIRST + i) : '0;
      head_q <= '0;
      tail_q <= AW'(NFREE);
      count  <= CW'(NFREE);
    end else begin
      for (int k = 0; k < GROUP; k++)
        if (push_vld[k]) slots[wpos[k]] <= push_preg[k*PW +: PW];
      head_q <= head_q + AW'(pop_cnt);
      tail_q <= tail_q + AW'(npush);
      count  <= count + CW'(npush) - CW'(pop_cnt);
    end
  end

  // the queue never holds more than its depth
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(count) + 32'(npush)) <= (32'(DEPTH) + 32'(pop_cnt)));

  // nothing is taken that is not queued
  assert_pop_available_R9: assert property (@(posedge clk) disable iff (!rst_n)
    CW'(pop_cnt) <= count);
endmodule

// File: rtl/rn_map_table.sv
// Architectural-to-physical map with flat read ports; a later write port wins.
module rn_map_table #(
  parameter int AREGS = 32,
  parameter int AW    = 5,
  parameter int PW    = 6,
  parameter int GROUP = 2,
  parameter int NRD   = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NRD*AW-1:0]    rd_addr,
  output logic [NRD*PW-1:0]    rd_data,
  input  logic [GROUP-1:0]     wr_en,
  input  logic [GROUP*AW-1:0]  wr_addr,
  input  logic [GROUP*PW-1:0]  wr_data
);
  logic [PW-1:0] map_q [AREGS];

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rd_data[r*PW +: PW] = map_q[rd_addr[r*AW +: AW]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < AREGS; i++) map_q[i] <= PW'(i);
    end else begin
      for (int k = 0; k < GROUP; k++)
        if (wr_en[k]) map_q[wr_addr[k*AW +: AW]] <= wr_data[k*PW +: PW];
    end
  end

  for (genvar k = 0; k < GROUP; k++) begin : g_chk
    // register zero is never a rename target
    assert_zero_unwritten_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[k] |-> (wr_addr[k*AW +: AW] != '0));
  end

  assert_zero_pinned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    map_q[0] == '0);
endmodule

// File: rtl/rn_group_xlate.sv
// Combinational renaming of one group: allocation order and in-group forwarding.
module rn_group_xlate #(
  parameter int AW    = 5,
  parameter int PW    = 6,
  parameter int GROUP = 2
) (
  input  logic [GROUP-1:0]             slot_vld,
  input  logic [GROUP-1:0]             wr,
  input  logic [GROUP*AW-1:0]          dst,
  input  logic [GROUP*AW-1:0]          srca,
  input  logic [GROUP*AW-1:0]          srcb,
  input  logic [GROUP*PW-1:0]          map_a,
  input  logic [GROUP*PW-1:0]          map_b,
  input  logic [GROUP*PW-1:0]          map_d,
  input  logic [GROUP*PW-1:0]          peek,
  output logic [GROUP-1:0]             writer,
  output logic [$clog2(GROUP+1)-1:0]   need,
  output logic [GROUP*PW-1:0]          pdst,
  output logic [GROUP*PW-1:0]          pold,
  output logic [GROUP*PW-1:0]          psrca,
  output logic [GROUP*PW-1:0]          psrcb
);
  localparam int GW = $clog2(GROUP+1);

  logic [AW-1:0] d_a [GROUP];
  logic [AW-1:0] a_a [GROUP];
  logic [AW-1:0] b_a [GROUP];
  logic [PW-1:0] pk_a [GROUP];
  logic [PW-1:0] nd_a [GROUP];

  for (genvar j = 0; j < GROUP; j++) begin : g_unpack
    assign d_a[j]  = dst[j*AW +: AW];
    assign a_a[j]  = srca[j*AW +: AW];
    assign b_a[j]  = srcb[j*AW +: AW];
    assign pk_a[j] = peek[j*PW +: PW];
  end

  // allocation: each writer takes the next free entry in slot order
  always_comb begin
    logic [GW-1:0] n;
    n = '0;
    for (int j = 0; j < GROUP; j++) begin
      writer[j] = slot_vld[j] & wr[j] & (d_a[j] != '0);
      nd_a[j]   = '0;
      if (writer[j]) begin
        nd_a[j] = pk_a[n];
        n       = n + GW'(1);
      end
    end
    need = n;
  end

  // translation with forwarding from earlier writers (latest earlier slot wins)
  always_comb begin
    for (int j = 0; j < GROUP; j++) begin
      logic [PW-1:0] ta, tb, to;
      ta = map_a[j*PW +: PW];
      tb = map_b[j*PW +: PW];
      to = writer[j] ? map_d[j*PW +: PW] : '0;
      for (int i = 0; i < GROUP; i++) begin
        if (i < j && writer[i]) begin
          if (d_a[i] == a_a[j]) ta = nd_a[i];
          if (d_a[i] == b_a[j]) tb = nd_a[i];
          if (writer[j] && d_a[i] == d_a[j]) to = nd_a[i];
        end
      end
      psrca[j*PW +: PW] = ta;
      psrcb[j*PW +: PW] = tb;
      pold[j*PW +: PW]  = to;
      pdst[j*PW +: PW]  = nd_a[j];
    end
  end
endmodule

// File: rtl/rename_unit.sv
module rename_unit #(
  parameter int AREGS = rn_pkg::RN_AREGS,
  parameter int PREGS = rn_pkg::RN_PREGS,
  parameter int GROUP = rn_pkg::RN_GROUP
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   in_valid,
  output logic                                   in_ready,
  input  logic [GROUP-1:0]                       in_slot_vld,
  input  logic [GROUP-1:0]                       in_wr,
  input  logic [GROUP*$clog2(AREGS)-1:0]         in_dst,
  input  logic [GROUP*$clog2(AREGS)-1:0]         in_srca,
  input  logic [GROUP*$clog2(AREGS)-1:0]         in_srcb,
  output logic                                   out_valid,
  input  logic                                   out_ready,
  output logic [GROUP*$clog2(PREGS)-1:0]         out_pdst,
  output logic [GROUP*$clog2(PREGS)-1:0]         out_pold,
  output logic [GROUP*$clog2(PREGS)-1:0]         out_psrca,
  output logic [GROUP*$clog2(PREGS)-1:0]         out_psrcb,
  input  logic [GROUP-1:0]                       cm_free,
  input  logic [GROUP*$clog2(PREGS)-1:0]         cm_preg
);
  localparam int AW    = $clog2(AREGS);
  localparam int PW    = $clog2(PREGS);
  localparam int CW    = $clog2(PREGS+1);
  localparam int GW    = $clog2(GROUP+1);
  localparam int NFREE = PREGS - AREGS;
  localparam int NRD   = 3 * GROUP;

  logic [NRD*PW-1:0]   rd_data;
  logic [GROUP*PW-1:0] peek;
  logic [CW-1:0]       free_cnt;
  logic [GROUP-1:0]    writer;
  logic [GW-1:0]       need;
  logic                room, fire;

  rn_map_table #(.AREGS(AREGS), .AW(AW), .PW(PW), .GROUP(GROUP), .NRD(NRD)) u_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr ({in_dst, in_srcb, in_srca}),
    .rd_data (rd_data),
    .wr_en   (writer & {GROUP{fire}}),
    .wr_addr (in_dst),
    .wr_data (out_pdst)
  );

  rn_free_list #(.DEPTH(PREGS), .PW(PW), .GROUP(GROUP), .NFREE(NFREE), .FIRST(AREGS)) u_free (
    .clk       (clk),
    .rst_n     (rst_n),
    .pop_cnt   (fire ? need : '0),
    .push_vld  (cm_free),
    .push_preg (cm_preg),
    .peek      (peek),
    .count     (free_cnt)
  );

  rn_group_xlate #(.AW(AW), .PW(PW), .GROUP(GROUP)) u_xlate (
    .slot_vld (in_slot_vld),
    .wr       (in_wr),
    .dst      (in_dst),
    .srca     (in_srca),
    .srcb     (in_srcb),
    .map_a    (rd_data[0 +: GROUP*PW]),
    .map_b    (rd_data[GROUP*PW +: GROUP*PW]),
    .map_d    (rd_data[2*GROUP*PW +: GROUP*PW]),
    .peek     (peek),
    .writer   (writer),
    .need     (need),
    .pdst     (out_pdst),
    .pold     (out_pold),
    .psrca    (out_psrca),
    .psrcb    (out_psrcb)
  );

  assign room      = free_cnt >= CW'(need);
  assign out_valid = in_valid & room;
  assign in_ready  = out_ready & room;
  assign fire      = in_valid & in_ready;

  for (genvar j = 0; j < GROUP; j++) begin : g_chk_slot
    // an allocated register is never the pinned zero register
    assert_writer_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && writer[j]) |-> (out_pdst[j*PW +: PW] != '0));
    for (genvar i = 0; i < j; i++) begin : g_pair
      assert_fresh_dest_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && writer[i] && writer[j]) |-> (out_pdst[i*PW +: PW] != out_pdst[j*PW +: PW]));
    end
  end

  assert_stall_short_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (free_cnt < CW'(need)) |-> !in_ready);

  assert_backpressure_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |-> !in_ready);

  // without acceptance the free count can only grow by returned registers
  assert_no_silent_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && cm_free == '0) |=> $stable(free_cnt));
endmodule

// File: tb/rename_unit_test.sv
module rename_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, out_ready = 1'b1;
  logic        in_ready, out_valid;
  logic [1:0]  in_slot_vld = '0, in_wr = '0, cm_free = '0;
  logic [9:0]  in_dst = '0, in_srca = '0, in_srcb = '0;
  logic [11:0] out_pdst, out_pold, out_psrca, out_psrcb, cm_preg = '0;

  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  rename_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_slot_vld(in_slot_vld), .in_wr(in_wr), .in_dst(in_dst),
    .in_srca(in_srca), .in_srcb(in_srcb), .out_valid(out_valid),
    .out_ready(out_ready), .out_pdst(out_pdst), .out_pold(out_pold),
    .out_psrca(out_psrca), .out_psrcb(out_psrcb), .cm_free(cm_free),
    .cm_preg(cm_preg)
  );

  typedef struct packed {
    logic       ordy;
    logic [1:0] svld, wr;
    logic [4:0] d0, d1, a0, b0, a1, b1;
    logic [1:0] cmf;
    logic [5:0] c0, c1;
    logic       erdy;
    logic [5:0] p0, p1, o0, o1, x0, y0, x1, y1;
  } vec_t;

  localparam vec_t VECS [6] = '{
    // two writers, slot 1 reads slot 0's destination (R3 R5)
    '{1'b1, 2'b11, 2'b11, 5'd1, 5'd4, 5'd2, 5'd3, 5'd1, 5'd1, 2'b00, 6'd0, 6'd0,
      1'b1, 6'd32, 6'd33, 6'd1, 6'd4, 6'd2, 6'd3, 6'd32, 6'd32},
    // both write r1 (R6), sources see the updated map (R4)
    '{1'b1, 2'b11, 2'b11, 5'd1, 5'd1, 5'd1, 5'd4, 5'd1, 5'd0, 2'b00, 6'd0, 6'd0,
      1'b1, 6'd34, 6'd35, 6'd32, 6'd34, 6'd32, 6'd33, 6'd34, 6'd0},
    // slot 0 no write, slot 1 writes r0 (R7); commit returns 1 and 4 (R8)
    '{1'b1, 2'b11, 2'b10, 5'd5, 5'd0, 5'd1, 5'd4, 5'd5, 5'd1, 2'b11, 6'd1, 6'd4,
      1'b1, 6'd0, 6'd0, 6'd0, 6'd0, 6'd35, 6'd33, 6'd5, 6'd35},
    // slot 0 invalid: no allocation, no forwarding; slot 1 takes the head (R3)
    '{1'b1, 2'b10, 2'b11, 5'd7, 5'd6, 5'd2, 5'd3, 5'd7, 5'd1, 2'b00, 6'd0, 6'd0,
      1'b1, 6'd0, 6'd36, 6'd0, 6'd6, 6'd2, 6'd3, 6'd7, 6'd35},
    // consumer stalls: not taken (R10)
    '{1'b0, 2'b01, 2'b01, 5'd2, 5'd0, 5'd6, 5'd6, 5'd0, 5'd0, 2'b00, 6'd0, 6'd0,
      1'b0, 6'd37, 6'd0, 6'd2, 6'd0, 6'd36, 6'd36, 6'd0, 6'd0},
    // same group accepted: 37 still at head
    '{1'b1, 2'b01, 2'b01, 5'd2, 5'd0, 5'd6, 5'd6, 5'd0, 5'd0, 2'b00, 6'd0, 6'd0,
      1'b1, 6'd37, 6'd0, 6'd2, 6'd0, 6'd36, 6'd36, 6'd0, 6'd0}
  };

  function automatic int pd(int j); return int'(out_pdst[j*6 +: 6]); endfunction
  function automatic int po(int j); return int'(out_pold[j*6 +: 6]); endfunction
  function automatic int pa(int j); return int'(out_psrca[j*6 +: 6]); endfunction
  function automatic int pb(int j); return int'(out_psrcb[j*6 +: 6]); endfunction

  task automatic chk(input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic drive(input logic iv, input logic ordy, input logic [1:0] sv,
                       input logic [1:0] w, input logic [4:0] d0, input logic [4:0] d1,
                       input logic [4:0] a0, input logic [4:0] b0, input logic [4:0] a1,
                       input logic [4:0] b1, input logic [1:0] cf,
                       input logic [5:0] c0, input logic [5:0] c1);
    @(negedge clk);
    in_valid = iv; out_ready = ordy; in_slot_vld = sv; in_wr = w;
    in_dst = {d1, d0}; in_srca = {a1, a0}; in_srcb = {b1, b0};
    cm_free = cf; cm_preg = {c1, c0};
    #1;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10: no input valid, a writer offered: nothing taken
    drive(1'b0, 1'b1, 2'b01, 2'b01, 5'd1, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 2'b00, 6'd0, 6'd0);
    chk("R10 out_valid without in_valid", int'(out_valid), 0);
    chk("R10 in_ready independent of in_valid", int'(in_ready), 1);

    // R1 R2: identity map after reset
    drive(1'b1, 1'b1, 2'b11, 2'b00, 5'd0, 5'd0, 5'd31, 5'd0, 5'd17, 5'd5, 2'b00, 6'd0, 6'd0);
    chk("R1 psrca0 identity", pa(0), 31);
    chk("R2 psrcb0 r0", pb(0), 0);
    chk("R1 psrca1 identity", pa(1), 17);
    chk("R1 psrcb1 identity", pb(1), 5);
    chk("R7 pdst0 non-writer", pd(0), 0);

    foreach (VECS[k]) begin
      drive(1'b1, VECS[k].ordy, VECS[k].svld, VECS[k].wr, VECS[k].d0, VECS[k].d1,
            VECS[k].a0, VECS[k].b0, VECS[k].a1, VECS[k].b1, VECS[k].cmf,
            VECS[k].c0, VECS[k].c1);
      chk("R10 in_ready", int'(in_ready), int'(VECS[k].erdy));
      chk("R10 out_valid", int'(out_valid), 1);
      chk("R3 pdst0", pd(0), int'(VECS[k].p0));
      chk("R3 pdst1", pd(1), int'(VECS[k].p1));
      chk("R4 pold0", po(0), int'(VECS[k].o0));
      chk("R6 pold1", po(1), int'(VECS[k].o1));
      chk("R2 psrca0", pa(0), int'(VECS[k].x0));
      chk("R2 psrcb0", pb(0), int'(VECS[k].y0));
      chk("R5 psrca1", pa(1), int'(VECS[k].x1));
      chk("R5 psrcb1", pb(1), int'(VECS[k].y1));
    end

    // R1 R3: drain the rest of the original pool in pairs
    for (int k = 0; k < 13; k++) begin
      drive(1'b1, 1'b1, 2'b11, 2'b11, 5'd10, 5'd11, 5'd0, 5'd0, 5'd0, 5'd0, 2'b00, 6'd0, 6'd0);
      chk("R3 drain pdst0", pd(0), 38 + 2*k);
      chk("R3 drain pdst1", pd(1), 39 + 2*k);
    end

    // R8: returned registers follow the original pool
    drive(1'b1, 1'b1, 2'b11, 2'b11, 5'd10, 5'd11, 5'd0, 5'd0, 5'd0, 5'd0, 2'b00, 6'd0, 6'd0);
    chk("R8 in_ready last pair", int'(in_ready), 1);
    chk("R8 reuse pdst0", pd(0), 1);
    chk("R8 reuse pdst1", pd(1), 4);
    chk("R4 pold0 after drain", po(0), 62);

    // R9: empty list, writer-free group still passes; R4 map shows r10 -> 1
    drive(1'b1, 1'b1, 2'b11, 2'b00, 5'd0, 5'd0, 5'd10, 5'd11, 5'd0, 5'd0, 2'b00, 6'd0, 6'd0);
    chk("R9 no-writer group on empty list", int'(in_ready), 1);
    chk("R4 psrca0 r10", pa(0), 1);
    chk("R4 psrcb0 r11", pb(0), 4);

    // R9: empty list, same-cycle return does not help
    drive(1'b1, 1'b1, 2'b01, 2'b01, 5'd3, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 2'b01, 6'd9, 6'd0);
    chk("R9 stall with same-cycle return", int'(in_ready), 0);
    chk("R9 out_valid low on stall", int'(out_valid), 0);

    // R9: one free, two writers
    drive(1'b1, 1'b1, 2'b11, 2'b11, 5'd3, 5'd5, 5'd0, 5'd0, 5'd0, 5'd0, 2'b00, 6'd0, 6'd0);
    chk("R9 stall one free two writers", int'(in_ready), 0);

    // R3 R8: lone slot 1 writer takes the returned register
    drive(1'b1, 1'b1, 2'b10, 2'b10, 5'd0, 5'd5, 5'd0, 5'd0, 5'd0, 5'd0, 2'b00, 6'd0, 6'd0);
    chk("R9 single writer with one free", int'(in_ready), 1);
    chk("R8 pdst1 returned reg", pd(1), 9);
    chk("R4 pold1 r5", po(1), 5);

    drive(1'b0, 1'b1, 2'b00, 2'b00, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 2'b00, 6'd0, 6'd0);
    finish_run();
  end
endmodule